// File: doc/BRIEF.md
# Diagnostic Channel Interface Override Register

This block is a maintenance register that is loaded with one scan-in word at a time. The word can take over the adapter interface of one I/O channel, so that a diagnostic routine drives that channel's inbound interface lines from stored bits and not from the real adapter. There are four channels: code 0 selects the multiplexer channel, and codes 1 to 3 select selector channels 1 to 3. The same stored payload can instead be read as common-channel request and priority overrides. Each mode has its own sticky bit. A word that carries the clear bit drops both mode bits and the channel selection.

A 3-bit stop code is decoded into one-hot stop enables for the selector channel clock. The block also asserts a halt request when the chosen stop condition is met. The stop conditions are built from the clock phase pulses, step control and the in-tag delay chain. Any nonzero channel selection also raises a logout stop for the addressed selector channel, whether or not interface mode is on. Illegal words are refused and set a sticky error flag.

Scan word layout (bit positions): payload [14:0], channel select [16:15], interface-mode [17], priority-mode [18], clear [19], stop code [22:20].

Top module: `diag_ovr_top`

## Requirements
- R1: After a synchronous active-low reset, both modes are off, the channel select is 0, the stop code is 0, `cfg_err` is 0, every `ch_if` slice equals the matching `adp_if` slice, and all override, logout and stop outputs are 0.
- R2: With interface mode stored, the 15-bit slice of `ch_if` for channel c (bits 15c+14 down to 15c) equals the stored payload when c equals the stored select. The payload uses bus bits [7:0], parity [8], select-in [9], operational-in [10], request-in [11], address-in [12], status-in [13] and service-in [14].
- R3: Every channel slice that is not overridden under R2 equals its live `adp_if` slice, in the same cycle.
- R4: With priority mode stored, `prio_ovr_en` is 1, `pci_req_ovr` equals payload [3:0] (one bit per channel), `ls_req_ovr` equals payload [7:4], and `prio_lvl_ovr` equals payload [13:8] (2 bits per selector channel 1..3). Without priority mode, all four of these outputs are 0.
- R5: A load without the clear bit ORs its mode bits and select field into the stored values and replaces the payload and the stop code. Outputs reflect the new state in the cycle after the load edge.
- R6: A legal load with the clear bit set zeroes both mode bits, the channel select and `cfg_err`. It still loads the payload and the stop code.
- R7: A load is refused if the clear bit arrives with any mode bit, or if the mode bits after the OR would both be set. A refused load leaves all stored state unchanged and sets `cfg_err`, which holds until R6 clears it.
- R8: For a stored select s in 1..3, `logout_stop` bit s-1 is 1 and all other bits are 0. For s = 0, `logout_stop` is 0.
- R9: For a stored stop code k in 1..7, `stop_en` bit k-1 is the only bit set. Code 0 sets no bit.
- R10: `halt_req` follows the stop code: 1 follows `clk_a0`, 2 follows `clk_a1`, 3 is always 1 (step), 4 is tag_dly[0]&!tag_dly[1], 5 is tag_dly[1]&!tag_dly[2], 6 is tag_dly[2]&!in_tag, and 0 and 7 give 0 (code 7 only blocks the latch pulse).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_ld | input | 1 | Load strobe for scan_word |
| scan_word | input | 23 | Scan-in word |
| adp_if | input | 60 | Live adapter inbound lines, 15 per channel |
| clk_a0 | input | 1 | Selector clock phase A0 pulse |
| clk_a1 | input | 1 | Selector clock phase A1 pulse |
| tag_dly | input | 3 | In-tag delay stages 1..3 |
| in_tag | input | 1 | Current in-tag level |
| ch_if | output | 60 | Interface lines delivered to channels |
| prio_ovr_en | output | 1 | Priority overrides active |
| pci_req_ovr | output | 4 | PCI request override per channel |
| ls_req_ovr | output | 4 | Local-storage request override per channel |
| prio_lvl_ovr | output | 6 | Priority level per selector channel |
| logout_stop | output | 3 | Logout stop per selector channel |
| stop_en | output | 7 | One-hot stop enables |
| halt_req | output | 1 | Selected stop condition met |
| cfg_err | output | 1 | Sticky illegal-load flag |

## Verification
The assertions assume that `scan_ld` and `scan_word` are stable at the clock edge. They also assume that reset is applied before the first load, so the stored mode bits start out mutually exclusive. The stimulus drives all inputs only at falling edges and begins with a reset. Its random words set each mode bit and the clear bit often enough to produce both legal and refused loads, and it adds directed words for both-modes, clear-with-mode and every stop code.

// File: rtl/diag_ovr_pkg.sv
// Shared widths, scan word layout and types for the diagnostic override register.
package diag_ovr_pkg;
    localparam int NCH     = 4;              // multiplexer channel + 3 selector channels
    localparam int CSEL_W  = $clog2(NCH);
    localparam int BUS_W   = 8;
    localparam int IF_W    = BUS_W + 7;      // bus, parity, six tags
    localparam int STOP_W  = 3;
    localparam int NSTOP   = (1 << STOP_W) - 1;
    localparam int NSEL    = NCH - 1;        // selector channels
    localparam int LVL_W   = 2;
    localparam int WORD_W  = STOP_W + 3 + CSEL_W + IF_W;

    // Packed MSB first: stop[22:20] clr[19] prm[18] ifm[17] csel[16:15] pay[14:0]
    typedef struct packed {
        logic [STOP_W-1:0] stop;
        logic              clr;
        logic              prm;
        logic              ifm;
        logic [CSEL_W-1:0] csel;
        logic [IF_W-1:0]   pay;
    } scan_word_t;
endpackage

// File: rtl/diag_scan_reg.sv
// Holds the scan-in state. Checks every word, refuses illegal ones and
// accumulates the sticky mode and select bits.
// Assumes: scan_ld and word are stable around the rising edge.
module diag_scan_reg
    import diag_ovr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  scan_word_t        word,
    output logic              ifm_q,
    output logic              prm_q,
    output logic [CSEL_W-1:0] csel_q,
    output logic [IF_W-1:0]   pay_q,
    output logic [STOP_W-1:0] stop_q,
    output logic              err_q
);
    logic bad;

    // Refuse clear combined with a mode bit, or two modes active after the OR.
    always_comb begin
        bad = (word.clr && (word.ifm || word.prm)) ||
              ((ifm_q || word.ifm) && (prm_q || word.prm));
    end

    // Update the stored state when a load strobe arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ifm_q  <= 1'b0;
            prm_q  <= 1'b0;
            csel_q <= '0;
            pay_q  <= '0;
            stop_q <= '0;
            err_q  <= 1'b0;
        end else if (ld) begin
            if (bad) begin
                err_q <= 1'b1;
            end else begin
                pay_q  <= word.pay;
                stop_q <= word.stop;
                if (word.clr) begin
                    ifm_q  <= 1'b0;
                    prm_q  <= 1'b0;
                    csel_q <= '0;
                    err_q  <= 1'b0;
                end else begin
                    ifm_q  <= ifm_q | word.ifm;
                    prm_q  <= prm_q | word.prm;
                    csel_q <= csel_q | word.csel;
                end
            end
        end
    end

    assert_modes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ifm_q && prm_q));
    assert_refused_keeps_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && bad) |=> ($stable(ifm_q) && $stable(prm_q) && $stable(csel_q) &&
                         $stable(pay_q) && $stable(stop_q) && err_q));
    assert_mode_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ifm_q && !(ld && word.clr)) |=> ifm_q);
    assert_clear_drops_modes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && word.clr && !word.ifm && !word.prm) |=> (!ifm_q && !prm_q && csel_q == '0 && !err_q));
endmodule

// File: rtl/diag_if_mux.sv
// Steers the stored payload onto one channel's interface, or onto the
// common-channel priority overrides, and decodes the logout stops.
// Assumes: ifm and prm never both high (guaranteed by diag_scan_reg).
module diag_if_mux
    import diag_ovr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ifm,
    input  logic                  prm,
    input  logic [CSEL_W-1:0]     csel,
    input  logic [IF_W-1:0]       pay,
    input  logic [NCH*IF_W-1:0]   adp_if,
    output logic [NCH*IF_W-1:0]   ch_if,
    output logic                  prio_en,
    output logic [NCH-1:0]        pci_req,
    output logic [NCH-1:0]        ls_req,
    output logic [NSEL*LVL_W-1:0] prio_lvl,
    output logic [NSEL-1:0]       logout
);
    // Replace the addressed channel's inbound lines with the payload.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_comb begin
            if (ifm && (csel == CSEL_W'(c)))
                ch_if[c*IF_W +: IF_W] = pay;
            else
                ch_if[c*IF_W +: IF_W] = adp_if[c*IF_W +: IF_W];
        end
    end

    // Read the payload as request and priority controls in priority mode.
    always_comb begin
        prio_en  = prm;
        pci_req  = prm ? pay[NCH-1:0] : '0;
        ls_req   = prm ? pay[2*NCH-1:NCH] : '0;
        prio_lvl = prm ? pay[2*NCH +: NSEL*LVL_W] : '0;
    end

    // One logout stop per selector channel, chosen by the select field.
    for (genvar s = 1; s < NCH; s++) begin : g_log
        assign logout[s-1] = (csel == CSEL_W'(s));
    end

    assert_logout_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(logout));
    assert_passthru_without_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ifm |-> (ch_if == adp_if));
    assert_prio_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !prm |-> (pci_req == '0 && ls_req == '0 && prio_lvl == '0));
endmodule

// File: rtl/diag_stop_dec.sv
// Decodes the stop code into one-hot enables and evaluates the halt condition.
// Assumes: tag_dly[0] is the first in-tag delay stage.
module diag_stop_dec
    import diag_ovr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STOP_W-1:0] code,
    input  logic              clk_a0,
    input  logic              clk_a1,
    input  logic [2:0]        tag_dly,
    input  logic              in_tag,
    output logic [NSTOP-1:0]  stop_en,
    output logic              halt
);
    // One enable per nonzero code.
    for (genvar k = 1; k <= NSTOP; k++) begin : g_en
        assign stop_en[k-1] = (code == STOP_W'(k));
    end

    // Evaluate the condition for the selected stop point.
    always_comb begin
        case (code)
            3'd1:    halt = clk_a0;
            3'd2:    halt = clk_a1;
            3'd3:    halt = 1'b1;
            3'd4:    halt = tag_dly[0] & ~tag_dly[1];
            3'd5:    halt = tag_dly[1] & ~tag_dly[2];
            3'd6:    halt = tag_dly[2] & ~in_tag;
            default: halt = 1'b0;
        endcase
    end

    assert_stop_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stop_en));
    assert_halt_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (stop_en[NSTOP-1:0] != '0 && !stop_en[NSTOP-1]));
endmodule

// File: rtl/diag_ovr_top.sv
// Top level of the diagnostic channel interface override register.
// Assumes: reset is applied before the first load.
module diag_ovr_top
    import diag_ovr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scan_ld,
    input  logic [WORD_W-1:0]     scan_word,
    input  logic [NCH*IF_W-1:0]   adp_if,
    input  logic                  clk_a0,
    input  logic                  clk_a1,
    input  logic [2:0]            tag_dly,
    input  logic                  in_tag,
    output logic [NCH*IF_W-1:0]   ch_if,
    output logic                  prio_ovr_en,
    output logic [NCH-1:0]        pci_req_ovr,
    output logic [NCH-1:0]        ls_req_ovr,
    output logic [NSEL*LVL_W-1:0] prio_lvl_ovr,
    output logic [NSEL-1:0]       logout_stop,
    output logic [NSTOP-1:0]      stop_en,
    output logic                  halt_req,
    output logic                  cfg_err
);
    scan_word_t        w;
    logic              ifm_q, prm_q;
    logic [CSEL_W-1:0] csel_q;
    logic [IF_W-1:0]   pay_q;
    logic [STOP_W-1:0] stop_q;

    assign w = scan_word_t'(scan_word);

    diag_scan_reg u_reg (
        .clk(clk), .rst_n(rst_n), .ld(scan_ld), .word(w),
        .ifm_q(ifm_q), .prm_q(prm_q), .csel_q(csel_q),
        .pay_q(pay_q), .stop_q(stop_q), .err_q(cfg_err)
    );

    diag_if_mux u_mux (
        .clk(clk), .rst_n(rst_n), .ifm(ifm_q), .prm(prm_q), .csel(csel_q),
        .pay(pay_q), .adp_if(adp_if), .ch_if(ch_if), .prio_en(prio_ovr_en),
        .pci_req(pci_req_ovr), .ls_req(ls_req_ovr), .prio_lvl(prio_lvl_ovr),
        .logout(logout_stop)
    );

    diag_stop_dec u_stop (
        .clk(clk), .rst_n(rst_n), .code(stop_q), .clk_a0(clk_a0), .clk_a1(clk_a1),
        .tag_dly(tag_dly), .in_tag(in_tag), .stop_en(stop_en), .halt(halt_req)
    );
endmodule

// File: tb/diag_ovr_top_tb_top.sv
// Self-checking bench: fixed-seed random words plus directed corner cases.
module diag_ovr_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        scan_ld;
    logic [22:0] scan_word;
    logic [59:0] adp_if;
    logic        clk_a0, clk_a1, in_tag;
    logic [2:0]  tag_dly;
    logic [59:0] ch_if;
    logic        prio_ovr_en, halt_req, cfg_err;
    logic [3:0]  pci_req_ovr, ls_req_ovr;
    logic [5:0]  prio_lvl_ovr;
    logic [2:0]  logout_stop;
    logic [6:0]  stop_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Bench model of the stored state.
    bit        m_ifm, m_prm, m_err;
    bit [1:0]  m_csel;
    bit [14:0] m_pay;
    bit [2:0]  m_stop;

    always #(CLK_PERIOD/2) clk = ~clk;

    diag_ovr_top dut_i (
        .clk(clk), .rst_n(rst_n), .scan_ld(scan_ld), .scan_word(scan_word),
        .adp_if(adp_if), .clk_a0(clk_a0), .clk_a1(clk_a1), .tag_dly(tag_dly),
        .in_tag(in_tag), .ch_if(ch_if), .prio_ovr_en(prio_ovr_en),
        .pci_req_ovr(pci_req_ovr), .ls_req_ovr(ls_req_ovr),
        .prio_lvl_ovr(prio_lvl_ovr), .logout_stop(logout_stop),
        .stop_en(stop_en), .halt_req(halt_req), .cfg_err(cfg_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [59:0] exp_ch();
        logic [59:0] r = adp_if;
        if (m_ifm) r[m_csel*15 +: 15] = m_pay;
        return r;
    endfunction

    function automatic logic exp_halt();
        case (m_stop)
            3'd1: return clk_a0;
            3'd2: return clk_a1;
            3'd3: return 1'b1;
            3'd4: return tag_dly[0] & ~tag_dly[1];
            3'd5: return tag_dly[1] & ~tag_dly[2];
            3'd6: return tag_dly[2] & ~in_tag;
            default: return 1'b0;
        endcase
    endfunction

    // Apply the load rules (R5, R6, R7) to the model.
    task automatic model_load(input logic [22:0] wd);
        bit ifm = wd[17], prm = wd[18], clr = wd[19];
        if ((clr && (ifm || prm)) || ((m_ifm | ifm) && (m_prm | prm))) begin
            m_err = 1;
        end else begin
            m_pay  = wd[14:0];
            m_stop = wd[22:20];
            if (clr) begin
                m_ifm = 0; m_prm = 0; m_csel = 0; m_err = 0;
            end else begin
                m_ifm  = m_ifm | ifm;
                m_prm  = m_prm | prm;
                m_csel = m_csel | wd[16:15];
            end
        end
    endtask

    task automatic check_all(input string ctx);
        check({ctx, " R2/R3 ch_if"}, 64'(ch_if), 64'(exp_ch()));
        check({ctx, " R4 prio_en"}, 64'(prio_ovr_en), 64'(m_prm));
        check({ctx, " R4 pci"}, 64'(pci_req_ovr), m_prm ? 64'(m_pay[3:0]) : 64'd0);
        check({ctx, " R4 ls"}, 64'(ls_req_ovr), m_prm ? 64'(m_pay[7:4]) : 64'd0);
        check({ctx, " R4 lvl"}, 64'(prio_lvl_ovr), m_prm ? 64'(m_pay[13:8]) : 64'd0);
        check({ctx, " R8 logout"}, 64'(logout_stop), (m_csel == 0) ? 64'd0 : 64'(3'b1 << (m_csel - 1)));
        check({ctx, " R9 stop_en"}, 64'(stop_en), (m_stop == 0) ? 64'd0 : 64'(7'b1 << (m_stop - 1)));
        check({ctx, " R10 halt"}, 64'(halt_req), 64'(exp_halt()));
        check({ctx, " R7 err"}, 64'(cfg_err), 64'(m_err));
    endtask

    task automatic rand_live();
        adp_if  = {$urandom, $urandom};
        clk_a0  = 1'($urandom);
        clk_a1  = 1'($urandom);
        tag_dly = 3'($urandom);
        in_tag  = 1'($urandom);
    endtask

    // One cycle: drive at falling edge, update model, check after rising edge.
    task automatic step(input bit ld, input logic [22:0] wd, input string ctx);
        @(negedge clk);
        scan_ld = ld;
        scan_word = wd;
        rand_live();
        @(posedge clk);
        if (ld) model_load(wd);
        #1;
        check_all(ctx);
    endtask

    function automatic logic [22:0] mk(input bit [2:0] stp, input bit clr, input bit prm,
                                       input bit ifm, input bit [1:0] cs, input bit [14:0] pay);
        return {stp, clr, prm, ifm, cs, pay};
    endfunction

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 0; scan_ld = 0; scan_word = '0;
        rand_live();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        check_all("R1 reset");
        check("R1 ch_if passthru", 64'(ch_if), 64'(adp_if));

        // R2: interface mode on selector channel 2.
        step(1, mk(3'd0, 0, 0, 1, 2'd2, 15'h5a3c), "R2 ifm ch2");
        step(0, '0, "R3 live change");
        // R5: OR-accumulating select 2|1 -> 3, payload replaced.
        step(1, mk(3'd1, 0, 0, 0, 2'd1, 15'h1234), "R5 sticky");
        check("R5 logout ch3", 64'(logout_stop), 64'd4);
        // R7: priority mode while interface mode held -> refused.
        step(1, mk(3'd5, 0, 1, 0, 2'd0, 15'h7fff), "R7 both modes");
        check("R7 err set", 64'(cfg_err), 64'd1);
        // R7: clear with mode bit -> refused.
        step(1, mk(3'd0, 1, 0, 1, 2'd0, 15'h0), "R7 clr+mode");
        // R6: legal clear.
        step(1, mk(3'd6, 1, 0, 0, 2'd3, 15'h0f0f), "R6 clear");
        check("R6 err cleared", 64'(cfg_err), 64'd0);
        // R4: priority mode.
        step(1, mk(3'd3, 0, 1, 0, 2'd0, 15'h2d96), "R4 prm");
        check("R4 halt step", 64'(halt_req), 64'd1);
        step(1, mk(3'd0, 1, 0, 0, 2'd0, 15'h0), "R6 clear2");
        // R9/R10: every stop code.
        for (int k = 0; k < 8; k++) begin
            step(1, mk(3'(k), 0, 0, 0, 2'd0, 15'(k)), "R9 code sweep");
            for (int j = 0; j < 3; j++) step(0, '0, "R10 conds");
        end
        // R8: mpx channel override, no logout.
        step(1, mk(3'd0, 0, 0, 1, 2'd0, 15'h4321), "R8 mpx");

        // Random mix.
        for (int i = 0; i < 600; i++) begin
            logic [22:0] wd = 23'($urandom);
            wd[17] = ($urandom_range(3) == 0);
            wd[18] = ($urandom_range(3) == 0);
            wd[19] = ($urandom_range(5) == 0);
            step(1'($urandom), wd, "RND");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule